// File: doc/BRIEF.md
# Character LCD parallel bus writer

This block moves one command or data byte at a time onto the parallel bus of a character LCD module. A client offers a byte, a register-select flag and a raw-nibble flag on a valid/ready handshake. The block then drives the register-select, read/write and enable lines and the eight data lines. Setup time, enable pulse width and hold time are all counted in system clocks, and every count is rounded up from the clock frequency parameter.

A static input chooses between an 8-bit bus, where a whole byte goes out under one enable strobe, and a 4-bit bus, where the byte is split into two strobes on the upper four data lines. The upper nibble goes first. The raw-nibble flag asks for a single strobe that carries only the upper four bits of the byte; power-up initialization sequences need this. The block never reads the module and never polls its busy flag. After each transfer it waits a fixed time chosen by the command instead, and it accepts nothing new until that wait has run out.

Top module: `lcd_wr_top`

## Requirements
- R1: After synchronous reset, in_ready is 1 and lcd_e, lcd_rw, lcd_rs and lcd_db are all 0.
- R2: A transfer is taken on a clock edge where in_valid and in_ready are both 1. in_ready is 0 from the next cycle until the post-write wait ends. Bytes offered while in_ready is 0 produce no strobe and are not taken.
- R3: lcd_rs carries in_rs for the whole transfer (0 = instruction register, 1 = data register), and lcd_rw is always 0.
- R4: With bus_4bit = 0 and in_raw = 0, one enable strobe carries all eight bits of in_byte on lcd_db[7:0]. The data is already present before lcd_e rises and stays unchanged until after lcd_e falls.
- R5: With bus_4bit = 1 and in_raw = 0, two strobes are sent. The first carries in_byte[7:4] on lcd_db[7:4], and the second carries in_byte[3:0] on lcd_db[7:4]. lcd_db[3:0] is 0 during both.
- R6: With in_raw = 1, in either bus mode, exactly one strobe is sent, carrying in_byte[7:4] on lcd_db[7:4] with lcd_db[3:0] = 0.
- R7: lcd_e stays high for ceil(max(T_PW_NS, T_DSW_NS) * CLK_HZ / 1e9) cycles. Before each rise it is low for at least the setup count, and one high plus low period lasts at least the cycle-time count. After each fall, data and lcd_rs are held for at least one cycle.
- R8: The post-write wait is the long count (T_LONG_NS) when in_rs = 0, in_raw = 0, in_byte[7:2] = 0 and in_byte[1:0] is not 0; these are the clear and return-home instructions. Every other transfer uses the short count (T_SHORT_NS).
- R9: The busy span, counted in cycles with in_ready low, equals strobes × (setup + high + hold) + wait. Each count is the nanosecond parameter times CLK_HZ / 1e9, rounded up, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_4bit | input | 1 | Static bus width select: 1 = four data lines, 0 = eight |
| in_valid | input | 1 | Transfer offered |
| in_ready | output | 1 | Block idle and able to take a transfer |
| in_byte | input | 8 | Command or data byte |
| in_rs | input | 1 | Register select for this transfer |
| in_raw | input | 1 | Send only the upper nibble as a single strobe |
| lcd_rs | output | 1 | Register select to the module |
| lcd_rw | output | 1 | Read/write line, held at write (0) |
| lcd_e | output | 1 | Enable strobe; the module latches on its falling edge |
| lcd_db | output | 8 | Data lines |

## Verification
The bench drives inputs on the falling clock edge and reads every output on the falling edge, half a cycle after the register that drives it has updated. A transfer offered at one falling edge is taken at the next rising edge, and in_ready reads 0 from the falling edge after that. The bench counts falling edges with in_ready low and compares the total with the R9 sum for the scaled clock it uses. Each strobe word is captured at the first falling edge where lcd_e reads low, which is inside the one-cycle hold. High and low run lengths of lcd_e are also taken at falling edges and compared against the rounded-up counts.

// File: rtl/lcd_wr_pkg.sv
package lcd_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_HOLD,
    ST_WAIT
  } wr_state_t;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int unsigned ns_to_cyc(longint unsigned ns, longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_wr_timer.sv
module lcd_wr_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/lcd_wr_fmt.sv
module lcd_wr_fmt (
  input  logic [7:0] byte_i,
  input  logic       rs_i,
  input  logic       raw_i,
  input  logic       bus4_i,
  output logic [7:0] first_o,
  output logic [7:0] second_o,
  output logic       two_o,
  output logic       long_o
);
  always_comb begin
    first_o  = (raw_i || bus4_i) ? {byte_i[7:4], 4'b0000} : byte_i;
    second_o = {byte_i[3:0], 4'b0000};
    two_o    = bus4_i && !raw_i;
    // clear display or cursor home instruction
    long_o   = !rs_i && !raw_i && (byte_i[7:2] == 6'd0) && (byte_i[1:0] != 2'd0);
  end
endmodule

// File: rtl/lcd_wr_top.sv
module lcd_wr_top
  import lcd_wr_pkg::*;
#(
  parameter longint unsigned CLK_HZ     = 50_000_000,
  parameter longint unsigned T_AS_NS    = 40,
  parameter longint unsigned T_PW_NS    = 230,
  parameter longint unsigned T_DSW_NS   = 80,
  parameter longint unsigned T_H_NS     = 10,
  parameter longint unsigned T_CYC_NS   = 500,
  parameter longint unsigned T_SHORT_NS = 40_000,
  parameter longint unsigned T_LONG_NS  = 1_640_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_4bit,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_byte,
  input  logic       in_rs,
  input  logic       in_raw,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [7:0] lcd_db
);
  localparam int unsigned N_HIGH  = max_u(ns_to_cyc(T_PW_NS, CLK_HZ), ns_to_cyc(T_DSW_NS, CLK_HZ));
  localparam int unsigned N_CYC   = ns_to_cyc(T_CYC_NS, CLK_HZ);
  localparam int unsigned N_SETUP = max_u(ns_to_cyc(T_AS_NS, CLK_HZ),
                                          (N_CYC > N_HIGH) ? N_CYC - N_HIGH : 1);
  localparam int unsigned N_HOLD  = ns_to_cyc(T_H_NS, CLK_HZ);
  localparam int unsigned N_SHORT = ns_to_cyc(T_SHORT_NS, CLK_HZ);
  localparam int unsigned N_LONG  = ns_to_cyc(T_LONG_NS, CLK_HZ);
  localparam int unsigned N_MAX   = max_u(max_u(N_LONG, N_SHORT), max_u(N_SETUP, max_u(N_HIGH, N_HOLD)));
  localparam int          CW      = $clog2(N_MAX + 1);

  wr_state_t state_q;
  logic [7:0] first_w, second_w, second_q;
  logic       two_w, long_w, two_q, long_q;
  logic       tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;
  logic       accept;

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign lcd_rw   = 1'b0;

  lcd_wr_fmt fmt_i (
    .byte_i  (in_byte),
    .rs_i    (in_rs),
    .raw_i   (in_raw),
    .bus4_i  (bus_4bit),
    .first_o (first_w),
    .second_o(second_w),
    .two_o   (two_w),
    .long_o  (long_w)
  );

  lcd_wr_timer #(.W(CW)) tmr_i (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_done)
  );

  // timer reload for the phase entered at this edge
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE:  if (accept) begin tmr_load = 1'b1; tmr_val = CW'(N_SETUP - 1); end
      ST_SETUP: if (tmr_done) begin tmr_load = 1'b1; tmr_val = CW'(N_HIGH - 1); end
      ST_HIGH:  if (tmr_done) begin tmr_load = 1'b1; tmr_val = CW'(N_HOLD - 1); end
      ST_HOLD:  if (tmr_done) begin
                  tmr_load = 1'b1;
                  if (two_q)       tmr_val = CW'(N_SETUP - 1);
                  else if (long_q) tmr_val = CW'(N_LONG - 1);
                  else             tmr_val = CW'(N_SHORT - 1);
                end
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      lcd_e    <= 1'b0;
      lcd_rs   <= 1'b0;
      lcd_db   <= 8'h00;
      second_q <= 8'h00;
      two_q    <= 1'b0;
      long_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q  <= ST_SETUP;
          lcd_rs   <= in_rs;
          lcd_db   <= first_w;
          second_q <= second_w;
          two_q    <= two_w;
          long_q   <= long_w;
        end
        ST_SETUP: if (tmr_done) begin
          state_q <= ST_HIGH;
          lcd_e   <= 1'b1;
        end
        ST_HIGH: if (tmr_done) begin
          state_q <= ST_HOLD;
          lcd_e   <= 1'b0;
        end
        ST_HOLD: if (tmr_done) begin
          if (two_q) begin
            state_q <= ST_SETUP;
            lcd_db  <= second_q;
            two_q   <= 1'b0;
          end else begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: if (tmr_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  rise_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lcd_e) |-> ($stable(lcd_db) && $stable(lcd_rs)));

  // R4
  fall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_e) |-> ($stable(lcd_db) && $stable(lcd_rs)));

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !lcd_e);

  // R5
  nibble_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (lcd_e && bus_4bit) |-> (lcd_db[3:0] == 4'h0));

  // R7
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lcd_e) |=> lcd_e);
endmodule

// File: tb/lcd_wr_top_tb_top.sv
module lcd_wr_top_tb_top;
  // scaled clock frequency keeps the long wait short in simulation
  localparam longint unsigned HZ = 5_000_000;
  // R9 rounding: 40ns->1, max(230,80)ns->2, 10ns->1, 500ns->3, 40us->200, 1.64ms->8200
  localparam int SU = 1, HI = 2, HD = 1, CYC = 3, SHORT = 200, LONG = 8200;

  logic clk = 0, rst = 1, bus_4bit = 0, in_valid = 0, in_rs = 0, in_raw = 0;
  logic [7:0] in_byte = 0;
  logic in_ready, lcd_rs, lcd_rw, lcd_e;
  logic [7:0] lcd_db;

  int vec = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lcd_wr_top #(.CLK_HZ(HZ)) dut_i (
    .clk(clk), .rst(rst), .bus_4bit(bus_4bit), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_rs(in_rs), .in_raw(in_raw),
    .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e), .lcd_db(lcd_db)
  );

  // strobe monitor on falling clock edges
  logic [7:0] log_db [0:3];
  logic       log_rs [0:3];
  int log_n = 0, hi_run = 0, lo_run = 0, last_hi = 0, min_lo = 1000000;
  bit prev_e = 0, rw_seen = 0;

  always @(negedge clk) begin
    if (lcd_rw) rw_seen <= 1;
    if (lcd_e) begin
      if (!prev_e && lo_run < min_lo) min_lo = lo_run;
      hi_run = hi_run + 1;
    end else begin
      if (prev_e) begin
        if (log_n < 4) begin log_db[log_n] = lcd_db; log_rs[log_n] = lcd_rs; end
        log_n   = log_n + 1;
        last_hi = hi_run;
        hi_run  = 0;
        lo_run  = 0;
      end
      lo_run = lo_run + 1;
    end
    prev_e = lcd_e;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_idle(output int busy);
    busy = 0;
    while (!in_ready && busy < 20000) begin busy++; @(negedge clk); end
  endtask

  // one transfer with full result checks
  task automatic xfer(input logic [7:0] b, input logic rs, input logic raw, input logic b4,
                      input int nstr, input logic [7:0] w0, input logic [7:0] w1,
                      input int wt, input string req);
    int busy;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    bus_4bit = b4;
    log_n = 0; min_lo = 1000000;
    in_byte = b; in_rs = rs; in_raw = raw; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    wait_idle(busy);
    chk(log_n == nstr, {req, " strobe count"}, log_n, nstr);
    if (nstr >= 1) begin
      chk(log_db[0] == w0, {req, " first word"}, log_db[0], w0);
      chk(log_rs[0] == rs, "R3 rs on strobe", log_rs[0], rs);
    end
    if (nstr >= 2) chk(log_db[1] == w1, {req, " second word"}, log_db[1], w1);
    chk(busy == nstr * (SU + HI + HD) + wt, "R9/R8 busy span", busy, nstr * (SU + HI + HD) + wt);
    chk(last_hi == HI, "R7 E high width", last_hi, HI);
    chk(min_lo >= SU && min_lo + HI >= CYC, "R7 E low before rise", min_lo, SU);
  endtask

  task automatic t_reset;
    rst = 1;
    repeat (3) @(negedge clk);
    chk(in_ready == 1 && lcd_e == 0 && lcd_rw == 0 && lcd_rs == 0 && lcd_db == 0,
        "R1 reset state", {in_ready, lcd_e, lcd_rw, lcd_rs, lcd_db}, 12'h800);
    rst = 0;
  endtask

  task automatic t_busy_offer;
    int busy;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    bus_4bit = 0; log_n = 0;
    in_byte = 8'h41; in_rs = 1; in_raw = 0; in_valid = 1;
    @(negedge clk);
    in_byte = 8'h42;                         // offered while busy
    wait_idle(busy);
    chk(log_n == 1, "R2 no strobe from busy offer", log_n, 1);
    chk(log_db[0] == 8'h41, "R2 first byte kept", log_db[0], 8'h41);
    @(negedge clk);                          // offer taken at the edge before this
    in_valid = 0;
    wait_idle(busy);
    chk(log_n == 2 && log_db[1] == 8'h42, "R2 held offer taken after wait", log_db[1], 8'h42);
  endtask

  initial begin
    t_reset();
    xfer(8'hA5, 1, 0, 0, 1, 8'hA5, 8'h00, SHORT, "R4 data 8-bit");
    xfer(8'h0C, 0, 0, 0, 1, 8'h0C, 8'h00, SHORT, "R3 instr 8-bit");
    xfer(8'h01, 0, 0, 0, 1, 8'h01, 8'h00, LONG,  "R8 clear 8-bit");
    xfer(8'h01, 1, 0, 0, 1, 8'h01, 8'h00, SHORT, "R8 data 01 short");
    xfer(8'h03, 0, 0, 1, 2, 8'h00, 8'h30, LONG,  "R5 home 4-bit");
    xfer(8'h5E, 1, 0, 1, 2, 8'h50, 8'hE0, SHORT, "R5 data 4-bit");
    xfer(8'h3F, 0, 1, 1, 1, 8'h30, 8'h00, SHORT, "R6 raw 4-bit");
    xfer(8'h2C, 0, 1, 0, 1, 8'h20, 8'h00, SHORT, "R6 raw 8-bit");
    xfer(8'h02, 0, 1, 0, 1, 8'h00, 8'h00, SHORT, "R8 raw not long");
    t_busy_offer();
    chk(rw_seen == 0, "R3 rw held low", rw_seen, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vec++; bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule